// File: doc/BRIEF.md
# Dual-Mode Host Bus Register Interface

This block lets a host processor reach a bank of eight 16-bit registers through one set of pins that can behave as either of two bus styles. A strap input selects the style. In strobe mode the host drives an active-low chip select, an active-low read strobe and two active-low write strobes, one per byte. These arrive with no relation to the core clock, so the block synchronizes them and commits each write once the strobe is released. In clocked mode the host opens an access with an active-low cycle-start strobe. A level on the read pin marks the access as read or write, two active-low byte enables mark the valid lanes, and the block answers with an active-low ready pulse two or three clocks after the start. In clocked mode the host bus is sampled on the core clock.

A size input picks a 16-bit or an 8-bit data path. On the 8-bit path all data moves on the low eight data pins. The top data pin then acts as a byte-select address: 1 selects the register's upper byte and 0 its lower byte. Toward the register bank the block presents a register index, single-cycle read and write enables, a per-byte write mask and write data. It takes combinational read data back. Two parameters describe the bank: one marks read-only slots, and one gives each slot's implemented bits.

Top module: `hbus_regif`

## Requirements
- R1: When mode_clk_i is 0 the strobe bus is used, and rdy_no stays 1 at all times. When mode_clk_i is 1 the clocked bus is used.
- R2: The register index reg_addr_o equals the host address addr_i (A[3:1]) of the access, covering all eight slots, and a read enable and a write enable never occur together.
- R3: In strobe mode on the 16-bit path, a low hb_ni sets reg_wmask_o[1] (bits 15:8) and a low lb_ni sets reg_wmask_o[0] (bits 7:0). The write is presented as a single-cycle reg_wr_o after the strobes are released, exactly once per access.
- R4: In strobe mode a read issues one reg_rd_o. data_o then holds the read value, and data_oe_o is 1 only while chip select and read strobe are both low (after synchronization), and 0 once they are released.
- R5: On the 8-bit path a write takes its byte from data_i[7:0]. data_i[15] = 1 gives reg_wmask_o = 2'b10 with the byte in bits 15:8, and data_i[15] = 0 gives 2'b01 with the byte in bits 7:0.
- R6: On the 8-bit path a read returns the byte chosen by data_i[15] (1 upper, 0 lower) on data_o[7:0], and data_o[15:8] is 0.
- R7: In clocked mode an access starts when as_ni and cs_ni are both low at a clock edge. rd_ni = 1 selects a read and 0 a write, a low hb_ni enables bits 15:8 and a low lb_ni enables bits 7:0, and address, data and enables are taken at the start edge.
- R8: In clocked mode with cyc3_i = 0, rdy_no is low in the second cycle counted from the start edge. With cyc3_i = 1 it is low in the third. Read data is valid with data_oe_o = 1 while rdy_no is low.
- R9: rdy_no is low for exactly one clock, and never goes low without a preceding start.
- R10: Writes to a slot marked in RO_MASK (default: slots 1 and 3) raise no reg_wr_o, and the slot keeps its value.
- R11: Read data bits not set in the slot's DEF_BITS field read as 0. By default slot 7 implements only bit 0 and the other slots all 16 bits.
- R12: In clocked mode a cycle-start strobe with cs_ni high is ignored, so no ready, read or write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, also the clocked-mode bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_clk_i | input | 1 | Bus style strap: 0 strobe bus, 1 clocked bus |
| size8_i | input | 1 | 1 selects the 8-bit data path |
| cyc3_i | input | 1 | Clocked mode: 1 for three-cycle, 0 for two-cycle accesses |
| cs_ni | input | 1 | Chip select, active low |
| as_ni | input | 1 | Clocked mode cycle-start strobe, active low |
| rd_ni | input | 1 | Strobe mode read strobe (low active); clocked mode read/write level (1 read) |
| hb_ni | input | 1 | High-byte write strobe or byte enable, active low |
| lb_ni | input | 1 | Low-byte write strobe or byte enable, active low |
| addr_i | input | 3 | Register select A[3:1] |
| data_i | input | 16 | Host write data; bit 15 is the byte select on the 8-bit path |
| data_o | output | 16 | Host read data |
| data_oe_o | output | 1 | Read data drive enable |
| rdy_no | output | 1 | Clocked mode cycle complete, active low |
| reg_addr_o | output | 3 | Register index to the bank |
| reg_rd_o | output | 1 | Single-cycle register read enable |
| reg_wr_o | output | 1 | Single-cycle register write enable |
| reg_wmask_o | output | 2 | Byte write mask, bit 1 for bits 15:8 |
| reg_wdata_o | output | 16 | Register write data |
| reg_rdata_i | input | 16 | Register read data for reg_addr_o |

## Verification
The checker watches on every cycle the invariants of the ready handshake: a one-clock pulse, always after a start, never in strobe mode, and read data enabled only with it. It also watches that write enables are single pulses that never target a read-only slot, that reads and writes are exclusive, and that 8-bit reads keep the upper lanes at zero. The bench scenarios are needed for the things no invariant can show. These are the data and byte mask that each access actually delivers, the byte steering of the top data pin, the masking of unimplemented bits, the exact two- or three-cycle latency, and that an ignored write leaves the slot unchanged.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int unsigned HB_AW   = 3;
  localparam int unsigned HB_DW   = 16;
  localparam int unsigned HB_BW   = 8;
  localparam int unsigned HB_NB   = HB_DW / HB_BW;
  localparam int unsigned HB_NREG = 1 << HB_AW;

  typedef logic [HB_AW-1:0] hb_addr_t;
  typedef logic [HB_DW-1:0] hb_word_t;

  // One request as produced by either bus front end
  typedef struct packed {
    logic             rd;     // single-cycle register read
    logic             wr;     // single-cycle register write
    hb_addr_t         addr;   // register index
    logic [HB_NB-1:0] lanes;  // byte lanes the host marked
    hb_word_t         wdata;  // raw host data
    logic             a0;     // byte select for the narrow path
    logic             oe;     // read data window
  } hb_req_t;

  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_WAIT = 2'd1,
    SC_ACC  = 2'd2,
    SC_RDY  = 2'd3
  } sc_state_t;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= {(STAGES*W){RST_VAL}};
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        st_q[i] <= st_q[i-1];
      end
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/hbus_async_fe.sv
module hbus_async_fe
  import hbus_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cs_ni,
  input  logic     rd_ni,
  input  logic     hb_ni,
  input  logic     lb_ni,
  input  hb_addr_t addr_i,
  input  hb_word_t data_i,
  output hb_req_t  req_o
);
  logic [3:0] raw_n, syn_n;
  logic       cs_a, rd_a, hb_a, lb_a;
  logic       wr_act, rd_act, commit;

  logic             wr_prev_q, wr_prev_d;
  logic             rd_prev_q, rd_prev_d;
  hb_addr_t         cap_addr_q, cap_addr_d;
  hb_word_t         cap_data_q, cap_data_d;
  logic [HB_NB-1:0] lanes_q, lanes_d;

  assign raw_n = {cs_ni, rd_ni, hb_ni, lb_ni};

  hbus_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_n),
    .q_o   (syn_n)
  );

  assign cs_a = ~syn_n[3];
  assign rd_a = ~syn_n[2];
  assign hb_a = ~syn_n[1];
  assign lb_a = ~syn_n[0];

  assign wr_act = cs_a & (hb_a | lb_a);
  assign rd_act = cs_a & rd_a;
  assign commit = wr_prev_q & ~wr_act;

  always_comb begin
    wr_prev_d  = wr_act;
    rd_prev_d  = rd_act;
    cap_addr_d = cap_addr_q;
    cap_data_d = cap_data_q;
    lanes_d    = '0;
    if (wr_act) begin
      cap_addr_d = addr_i;
      cap_data_d = data_i;
      lanes_d    = lanes_q | {hb_a, lb_a};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_prev_q  <= 1'b0;
      rd_prev_q  <= 1'b0;
      cap_addr_q <= '0;
      cap_data_q <= '0;
      lanes_q    <= '0;
    end else begin
      wr_prev_q  <= wr_prev_d;
      rd_prev_q  <= rd_prev_d;
      cap_addr_q <= cap_addr_d;
      cap_data_q <= cap_data_d;
      lanes_q    <= lanes_d;
    end
  end

  always_comb begin
    req_o       = '0;
    req_o.wr    = commit;
    req_o.rd    = rd_act & ~rd_prev_q;
    req_o.addr  = commit ? cap_addr_q : addr_i;
    req_o.lanes = lanes_q;
    req_o.wdata = cap_data_q;
    req_o.a0    = commit ? cap_data_q[HB_DW-1] : data_i[HB_DW-1];
    req_o.oe    = rd_act & rd_prev_q;
  end
endmodule

// File: rtl/hbus_clk_fe.sv
module hbus_clk_fe
  import hbus_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cyc3_i,
  input  logic     cs_ni,
  input  logic     as_ni,
  input  logic     rw_i,
  input  logic     hb_ni,
  input  logic     lb_ni,
  input  hb_addr_t addr_i,
  input  hb_word_t data_i,
  output hb_req_t  req_o,
  output logic     rdy_no
);
  sc_state_t        st_q, st_d;
  hb_addr_t         addr_q, addr_d;
  hb_word_t         data_q, data_d;
  logic             rw_q, rw_d;
  logic [HB_NB-1:0] lanes_q, lanes_d;
  logic             start;

  assign start = (st_q == SC_IDLE) & ~as_ni & ~cs_ni;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    data_d  = data_q;
    rw_d    = rw_q;
    lanes_d = lanes_q;
    unique case (st_q)
      SC_IDLE: if (start) begin
        st_d    = cyc3_i ? SC_WAIT : SC_ACC;
        addr_d  = addr_i;
        data_d  = data_i;
        rw_d    = rw_i;
        lanes_d = {~hb_ni, ~lb_ni};
      end
      SC_WAIT: st_d = SC_ACC;
      SC_ACC:  st_d = SC_RDY;
      SC_RDY:  st_d = SC_IDLE;
      default: st_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SC_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      rw_q    <= 1'b1;
      lanes_q <= '0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      rw_q    <= rw_d;
      lanes_q <= lanes_d;
    end
  end

  always_comb begin
    req_o       = '0;
    req_o.rd    = (st_q == SC_ACC) & rw_q;
    req_o.wr    = (st_q == SC_ACC) & ~rw_q;
    req_o.addr  = addr_q;
    req_o.lanes = lanes_q;
    req_o.wdata = data_q;
    req_o.a0    = data_q[HB_DW-1];
    req_o.oe    = (st_q == SC_RDY) & rw_q;
  end

  assign rdy_no = (st_q != SC_RDY);
endmodule

// File: rtl/hbus_steer.sv
module hbus_steer
  import hbus_pkg::*;
(
  input  logic             size8_i,
  input  hb_req_t          req_i,
  input  hb_word_t         rdata_i,
  input  hb_word_t         defbits_i,
  output logic [HB_NB-1:0] wmask_o,
  output hb_word_t         wdata_o,
  output hb_word_t         rword_o
);
  hb_word_t masked;
  logic     any_lane;

  assign any_lane = |req_i.lanes;
  assign masked   = rdata_i & defbits_i;

  for (genvar g = 0; g < HB_NB; g++) begin : g_lane
    assign wmask_o[g] = size8_i ? (any_lane & (req_i.a0 == 1'(g)))
                                : req_i.lanes[g];
    assign wdata_o[g*HB_BW +: HB_BW] = size8_i ? req_i.wdata[HB_BW-1:0]
                                               : req_i.wdata[g*HB_BW +: HB_BW];
  end

  always_comb begin
    if (size8_i) begin
      rword_o = '0;
      rword_o[HB_BW-1:0] = req_i.a0 ? masked[HB_DW-1 -: HB_BW]
                                    : masked[HB_BW-1:0];
    end else begin
      rword_o = masked;
    end
  end
endmodule

// File: rtl/hbus_regif.sv
module hbus_regif
  import hbus_pkg::*;
#(
  parameter int unsigned               SYNC_STAGES = 2,
  parameter logic [HB_NREG-1:0]        RO_MASK     = 8'b0000_1010,
  parameter logic [HB_NREG*HB_DW-1:0]  DEF_BITS    = {16'h0001, {7{16'hFFFF}}}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_clk_i,
  input  logic             size8_i,
  input  logic             cyc3_i,
  input  logic             cs_ni,
  input  logic             as_ni,
  input  logic             rd_ni,
  input  logic             hb_ni,
  input  logic             lb_ni,
  input  logic [2:0]       addr_i,
  input  logic [15:0]      data_i,
  output logic [15:0]      data_o,
  output logic             data_oe_o,
  output logic             rdy_no,
  output logic [2:0]       reg_addr_o,
  output logic             reg_rd_o,
  output logic             reg_wr_o,
  output logic [1:0]       reg_wmask_o,
  output logic [15:0]      reg_wdata_o,
  input  logic [15:0]      reg_rdata_i
);
  logic     rst_sn;
  hb_req_t  a_req, c_req, sel;
  logic     c_rdy_n;
  hb_word_t rword, defw;
  hb_word_t hold_q, hold_d;
  logic [HB_NB-1:0] wmask;

  // reset: asserted at once, released through two flops
  hbus_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_sn)
  );

  hbus_async_fe #(.SYNC_STAGES(SYNC_STAGES)) u_async (
    .clk_i (clk_i),
    .rst_ni(rst_sn),
    .cs_ni (cs_ni),
    .rd_ni (rd_ni),
    .hb_ni (hb_ni),
    .lb_ni (lb_ni),
    .addr_i(addr_i),
    .data_i(data_i),
    .req_o (a_req)
  );

  hbus_clk_fe u_clkd (
    .clk_i (clk_i),
    .rst_ni(rst_sn),
    .cyc3_i(cyc3_i),
    .cs_ni (cs_ni),
    .as_ni (as_ni),
    .rw_i  (rd_ni),
    .hb_ni (hb_ni),
    .lb_ni (lb_ni),
    .addr_i(addr_i),
    .data_i(data_i),
    .req_o (c_req),
    .rdy_no(c_rdy_n)
  );

  assign sel  = mode_clk_i ? c_req : a_req;
  assign defw = DEF_BITS[sel.addr*HB_DW +: HB_DW];

  hbus_steer u_steer (
    .size8_i  (size8_i),
    .req_i    (sel),
    .rdata_i  (reg_rdata_i),
    .defbits_i(defw),
    .wmask_o  (wmask),
    .wdata_o  (reg_wdata_o),
    .rword_o  (rword)
  );

  assign reg_addr_o  = sel.addr;
  assign reg_rd_o    = sel.rd;
  assign reg_wr_o    = sel.wr & (|wmask) & ~RO_MASK[sel.addr];
  assign reg_wmask_o = wmask;

  always_comb begin
    hold_d = hold_q;
    if (sel.rd) hold_d = rword;
  end

  always_ff @(posedge clk_i or negedge rst_sn) begin
    if (!rst_sn) hold_q <= '0;
    else         hold_q <= hold_d;
  end

  assign data_o    = hold_q;
  assign data_oe_o = sel.oe;
  assign rdy_no    = mode_clk_i ? c_rdy_n : 1'b1;
endmodule

// File: rtl/hbus_regif_chk.sv
module hbus_regif_chk #(
  parameter logic [7:0] RO_MASK = 8'b0000_1010
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mode_clk_i,
  input logic        size8_i,
  input logic        cs_ni,
  input logic        as_ni,
  input logic        rdy_no,
  input logic        reg_wr_o,
  input logic        reg_rd_o,
  input logic [2:0]  reg_addr_o,
  input logic [1:0]  reg_wmask_o,
  input logic [15:0] data_o,
  input logic        data_oe_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              pend_q <= 1'b0;
    else if (!rdy_no)                         pend_q <= 1'b0;
    else if (mode_clk_i && !as_ni && !cs_ni)  pend_q <= 1'b1;
  end

  assert_async_rdy_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_clk_i |-> rdy_no);

  assert_rd_wr_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_o && reg_rd_o));

  assert_wr_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

  assert_narrow_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && size8_i) |-> ($countones(reg_wmask_o) == 1));

  assert_narrow_hi_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && size8_i) |-> (data_o[15:8] == 8'h00));

  assert_clk_oe_rdy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_clk_i && data_oe_o) |-> !rdy_no);

  assert_rdy_one_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_no |=> rdy_no);

  assert_rdy_needs_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_no) |-> pend_q);

  assert_ro_blocked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> !RO_MASK[reg_addr_o]);
endmodule

bind hbus_regif hbus_regif_chk #(.RO_MASK(RO_MASK)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_clk_i (mode_clk_i),
  .size8_i    (size8_i),
  .cs_ni      (cs_ni),
  .as_ni      (as_ni),
  .rdy_no     (rdy_no),
  .reg_wr_o   (reg_wr_o),
  .reg_rd_o   (reg_rd_o),
  .reg_addr_o (reg_addr_o),
  .reg_wmask_o(reg_wmask_o),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o)
);

// File: tb/hbus_regif_bench.sv
module hbus_regif_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_clk, size8, cyc3;
  logic        cs_n, as_n, rd_n, hb_n, lb_n;
  logic [2:0]  addr;
  logic [15:0] din;
  logic [15:0] dout;
  logic        doe, rdy_n;
  logic [2:0]  r_addr;
  logic        r_rd, r_wr;
  logic [1:0]  r_mask;
  logic [15:0] r_wdata, r_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct packed {
    logic [2:0]  a;
    logic [1:0]  m;
    logic [15:0] d;
  } wexp_t;
  wexp_t wq[$];

  logic [15:0] rf  [8];
  logic [15:0] exp_rf [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  hbus_regif u_hbus_regif (
    .clk_i(clk), .rst_ni(rst_n), .mode_clk_i(mode_clk), .size8_i(size8),
    .cyc3_i(cyc3), .cs_ni(cs_n), .as_ni(as_n), .rd_ni(rd_n), .hb_ni(hb_n),
    .lb_ni(lb_n), .addr_i(addr), .data_i(din), .data_o(dout),
    .data_oe_o(doe), .rdy_no(rdy_n), .reg_addr_o(r_addr), .reg_rd_o(r_rd),
    .reg_wr_o(r_wr), .reg_wmask_o(r_mask), .reg_wdata_o(r_wdata),
    .reg_rdata_i(r_rdata)
  );

  // register bank model
  assign r_rdata = rf[r_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) rf[i] <= 16'h1111 * 16'(i + 1);
    end else if (r_wr) begin
      if (r_mask[1]) rf[r_addr][15:8] <= r_wdata[15:8];
      if (r_mask[0]) rf[r_addr][7:0]  <= r_wdata[7:0];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // scoreboard monitor for register writes (R3 R5 R7 R10)
  always @(negedge clk) begin
    if (rst_n && r_wr) begin
      if (wq.size() == 0) begin
        check(1'b0, "R10 unexpected register write", {13'd0, r_addr, r_wdata}, 32'd0);
      end else begin
        wexp_t e;
        logic [15:0] em;
        e  = wq.pop_front();
        em = {{8{e.m[1]}}, {8{e.m[0]}}};
        check(r_addr == e.a && r_mask == e.m && (r_wdata & em) == (e.d & em),
              "R3 R5 R7 scoreboard write",
              {11'd0, r_addr, r_mask, r_wdata & em}, {11'd0, e.a, e.m, e.d & em});
      end
    end
  end

  function automatic logic [15:0] defm(input logic [2:0] a);
    return (a == 3'd7) ? 16'h0001 : 16'hFFFF;   // R11
  endfunction

  function automatic bit is_ro(input logic [2:0] a);
    return (a == 3'd1) || (a == 3'd3);           // R10
  endfunction

  task automatic push_wr(input logic [2:0] a, input logic [1:0] m, input logic [15:0] d);
    if (!is_ro(a) && m != 2'b00) begin
      wq.push_back('{a: a, m: m, d: d});
      if (m[1]) exp_rf[a][15:8] = d[15:8];
      if (m[0]) exp_rf[a][7:0]  = d[7:0];
    end
  endtask

  task automatic idle_pins();
    cs_n = 1'b1; as_n = 1'b1; rd_n = 1'b1; hb_n = 1'b1; lb_n = 1'b1;
  endtask

  task automatic as_write(input logic [2:0] a, input logic [15:0] d,
                          input bit hi, input bit lo);
    logic [1:0] m;
    logic [15:0] wd;
    if (size8) begin
      m  = d[15] ? 2'b10 : 2'b01;
      wd = {d[7:0], d[7:0]};
    end else begin
      m  = {hi, lo};
      wd = d;
    end
    push_wr(a, m, wd);
    @(negedge clk);
    addr = a; din = d; cs_n = 1'b0; hb_n = ~hi; lb_n = ~lo;
    repeat (4) @(negedge clk);
    idle_pins();
    repeat (5) @(negedge clk);
    check(rdy_n == 1'b1, "R1 ready idle in strobe mode", {31'd0, rdy_n}, 32'd1);
  endtask

  task automatic as_read(input logic [2:0] a, input bit a0, input logic [15:0] expv,
                         input string tag);
    @(negedge clk);
    addr = a; din = {a0, 15'd0}; cs_n = 1'b0; rd_n = 1'b0;
    repeat (5) @(negedge clk);
    check(doe == 1'b1 && dout == expv, tag, {15'd0, doe, dout}, {15'd0, 1'b1, expv});
    idle_pins();
    repeat (4) @(negedge clk);
    check(doe == 1'b0, "R4 output enable drops after release", {31'd0, doe}, 32'd0);
  endtask

  task automatic ck_access(input bit rw, input logic [2:0] a, input logic [15:0] d,
                           input bit hi, input bit lo, input bit c3,
                           input logic [15:0] expv, input string tag);
    int n;
    if (!rw) begin
      if (size8) push_wr(a, d[15] ? 2'b10 : 2'b01, {d[7:0], d[7:0]});
      else       push_wr(a, {hi, lo}, d);
    end
    cyc3 = c3;
    @(negedge clk);
    addr = a; din = d; cs_n = 1'b0; as_n = 1'b0; rd_n = rw; hb_n = ~hi; lb_n = ~lo;
    n = 0;
    while (n < 8) begin
      @(negedge clk);
      n++;
      as_n = 1'b1;
      if (!rdy_n) break;
    end
    check(n == (c3 ? 3 : 2), "R8 ready latency", n, c3 ? 3 : 2);
    if (rw) check(doe == 1'b1 && dout == expv, tag, {15'd0, doe, dout}, {15'd0, 1'b1, expv});
    @(negedge clk);
    check(rdy_n == 1'b1, "R9 ready lasts one clock", {31'd0, rdy_n}, 32'd1);
    idle_pins();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_clk = 1'b0; size8 = 1'b0; cyc3 = 1'b0;
    addr = '0; din = '0;
    idle_pins();
    for (int i = 0; i < 8; i++) exp_rf[i] = 16'h1111 * 16'(i + 1);
    repeat (3) @(negedge clk);
    // reset state
    check(rdy_n == 1'b1 && doe == 1'b0 && r_wr == 1'b0 && r_rd == 1'b0,
          "R1 R9 reset outputs", {28'd0, rdy_n, doe, r_wr, r_rd}, 32'h8);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // strobe mode, 16-bit path
    as_write(3'd2, 16'hA5C3, 1, 1);                                   // R3 R2
    as_read(3'd2, 0, exp_rf[2], "R4 R2 read slot 2");
    as_write(3'd5, 16'h7700, 1, 0);                                   // R3 high byte only
    as_read(3'd5, 0, exp_rf[5], "R3 high byte write keeps low byte");
    as_write(3'd0, 16'h00EE, 0, 1);                                   // R3 low byte only
    as_read(3'd0, 0, exp_rf[0], "R3 low byte write keeps high byte");
    as_write(3'd1, 16'hDEAD, 1, 1);                                   // R10 read-only
    as_read(3'd1, 0, 16'h2222, "R10 read-only slot unchanged");
    as_read(3'd7, 0, 16'h8888 & defm(3'd7), "R11 undefined bits read 0");
    as_write(3'd7, 16'hFFFF, 1, 1);
    as_read(3'd7, 0, 16'h0001, "R11 only bit 0 implemented");

    // strobe mode, 8-bit path
    size8 = 1'b1;
    as_write(3'd4, {1'b1, 7'd0, 8'h3C}, 0, 1);                        // R5 upper byte
    as_read(3'd4, 1, 16'h003C, "R6 narrow read upper byte");
    as_read(3'd4, 0, 16'h0055, "R6 narrow read lower byte");
    as_write(3'd6, {1'b0, 7'd0, 8'h9A}, 0, 1);                        // R5 lower byte
    as_read(3'd6, 0, 16'h009A, "R5 narrow write lower byte");
    as_read(3'd6, 1, 16'h0077, "R5 upper byte untouched");

    // clocked mode
    mode_clk = 1'b1;
    size8    = 1'b0;
    repeat (2) @(negedge clk);
    ck_access(0, 3'd6, 16'hBEEF, 1, 1, 0, 16'h0, "");                 // R7 write
    ck_access(1, 3'd6, 16'h0000, 0, 0, 1, 16'hBEEF, "R7 R8 clocked read three-cycle");
    ck_access(0, 3'd0, 16'h0012, 0, 1, 1, 16'h0, "");                 // R7 low lane
    ck_access(1, 3'd0, 16'h0000, 0, 0, 0, exp_rf[0], "R7 low lane write two-cycle");
    ck_access(0, 3'd3, 16'h5A5A, 1, 1, 0, 16'h0, "");                 // R10
    ck_access(1, 3'd3, 16'h0000, 0, 0, 0, 16'h4444, "R10 clocked read-only write ignored");
    ck_access(1, 3'd7, 16'h0000, 0, 0, 0, 16'h0001, "R11 clocked read masked");

    // R12 start ignored without chip select
    @(negedge clk);
    as_n = 1'b0; cs_n = 1'b1; rd_n = 1'b0; hb_n = 1'b0; lb_n = 1'b0; addr = 3'd2;
    @(negedge clk);
    idle_pins();
    begin
      bit seen;
      seen = 1'b0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (!rdy_n || r_rd || r_wr) seen = 1'b1;
      end
      check(!seen, "R12 start without chip select ignored", {31'd0, seen}, 32'd0);
    end
    ck_access(1, 3'd2, 16'h0000, 0, 0, 0, exp_rf[2], "R12 slot 2 unchanged");

    // clocked 8-bit path
    size8 = 1'b1;
    ck_access(1, 3'd4, 16'h8000, 0, 0, 0, 16'h003C, "R6 clocked narrow upper byte");
    ck_access(0, 3'd5, {1'b0, 7'd0, 8'h42}, 0, 1, 1, 16'h0, "");      // R5
    ck_access(1, 3'd5, 16'h0000, 0, 0, 0, 16'h0042, "R5 clocked narrow write lower byte");

    check(wq.size() == 0, "R3 all expected writes seen", wq.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule